// File: doc/BRIEF.md
# Two-Wire Bus Unsticking Sequencer

This block sits beside a two-wire bus master and frees the bus when a target device has been left holding the data line low, for example after a transfer was cut short by a reset or a supply dip. A one-cycle request starts the sequence. The block pulses the clock line through its open-drain pull-down and looks at the data line near the end of every clock-high phase. The first time the data line reads high, the block creates a start condition and then a stop condition, which leaves the bus idle with both lines released.

The sequence has a fixed limit on the number of clock pulses. If the data line is still low when that limit is reached, the block reports failure and releases both lines. Every phase length is a parameter counted in system-clock cycles. The data-line input is synchronised inside the block before use. The block never drives a line high: each output is a pull-down enable, and a 0 on it means the line is released.

Top module: `twi_unstick`

## Requirements
- R1: After reset, and whenever no sequence is running, `scl_pull`, `sda_pull`, `done` and `fail` are all 0.
- R2: When `recover_req` is 1 at a rising clock edge while idle, `scl_pull` is 1 from that edge on.
- R3: Each clock-low phase during pulsing has `scl_pull` high for exactly LOW_CYC cycles. Each clock-high phase between two pulses lasts exactly HIGH_CYC cycles.
- R4: `sda_pull` stays 0 throughout the pulse train. The synchronised data line is sampled in the last cycle of each clock-high phase. The first high sample ends the pulsing, so a target that lets go after K pulses costs K+1 pulses.
- R5: The start condition raises `sda_pull` while `scl_pull` is 0. Before it, the clock has been released for HIGH_CYC+SETUP_CYC cycles. `sda_pull` then stays 1 for exactly HOLD_CYC cycles with the clock still released.
- R6: The stop condition drops `sda_pull` while `scl_pull` is 0. In that same cycle `done` is 1 for exactly one cycle, with both pulls at 0.
- R7: If the data line is still low at the sample of pulse number MAX_PULSES, `fail` is 1 for one cycle with both pulls at 0, and no start condition is produced.
- R8: A `recover_req` that arrives while a sequence is running has no effect. The pulse count and the outcome are unchanged, and no new sequence follows.
- R9: No sequence issues more than MAX_PULSES clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | One-cycle request to start a sequence |
| sda_in | input | 1 | Data line as read from the bus (asynchronous) |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| done | output | 1 | One-cycle pulse: bus freed, start and stop sent |
| fail | output | 1 | One-cycle pulse: data line still low after the pulse limit |

## Verification
The bench builds the block with LOW_CYC=6, HIGH_CYC=4, SETUP_CYC=3, HOLD_CYC=5, two synchroniser stages and the default limit of nine pulses. These short phases keep a whole sequence under about a hundred cycles, so many release points fit in one run. That includes a target that never lets go, one that lets go in time for the final sample, and one that lets go just too late. The two-stage synchroniser still settles well inside the six-cycle low phase, so the sample in each high phase always sees the data line as it is after the release.

// File: rtl/twiu_pkg.sv
package twiu_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOW   = 3'd1,
    PH_HIGH  = 3'd2,
    PH_SETUP = 3'd3,
    PH_HOLD  = 3'd4
  } phase_t;

endpackage

// File: rtl/twiu_sync.sv
module twiu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/twiu_timer.sv
module twiu_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/twiu_fsm.sv
module twiu_fsm
  import twiu_pkg::*;
#(
  parameter int LOW_CYC    = 260,
  parameter int HIGH_CYC   = 140,
  parameter int SETUP_CYC  = 130,
  parameter int HOLD_CYC   = 130,
  parameter int MAX_PULSES = 9,
  parameter int TW         = 9,
  parameter int PW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          sda_s,
  input  logic          t_expired,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          done,
  output logic          fail
);

  localparam logic [TW-1:0] LOW_LD   = TW'(LOW_CYC - 1);
  localparam logic [TW-1:0] HIGH_LD  = TW'(HIGH_CYC - 1);
  localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] HOLD_LD  = TW'(HOLD_CYC - 1);
  localparam logic [PW-1:0] PULSE_LIM = PW'(MAX_PULSES);

  phase_t        ph_q, ph_d;
  logic [PW-1:0] pulses_q, pulses_d;
  logic          done_d, fail_d;
  logic          scl_q, sda_q, done_q, fail_q;

  always_comb begin
    ph_d     = ph_q;
    pulses_d = pulses_q;
    t_load   = 1'b0;
    t_val    = '0;
    done_d   = 1'b0;
    fail_d   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req) begin
          ph_d     = PH_LOW;
          pulses_d = '0;
          t_load   = 1'b1;
          t_val    = LOW_LD;
        end
      end
      PH_LOW: begin
        if (t_expired) begin
          ph_d     = PH_HIGH;
          pulses_d = pulses_q + 1'b1;
          t_load   = 1'b1;
          t_val    = HIGH_LD;
        end
      end
      PH_HIGH: begin
        if (t_expired) begin
          if (sda_s) begin
            ph_d   = PH_SETUP;
            t_load = 1'b1;
            t_val  = SETUP_LD;
          end else if (pulses_q >= PULSE_LIM) begin
            ph_d   = PH_IDLE;
            fail_d = 1'b1;
          end else begin
            ph_d   = PH_LOW;
            t_load = 1'b1;
            t_val  = LOW_LD;
          end
        end
      end
      PH_SETUP: begin
        if (t_expired) begin
          ph_d   = PH_HOLD;
          t_load = 1'b1;
          t_val  = HOLD_LD;
        end
      end
      PH_HOLD: begin
        if (t_expired) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      pulses_q <= '0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      pulses_q <= pulses_d;
      scl_q    <= (ph_d == PH_LOW);
      sda_q    <= (ph_d == PH_HOLD);
      done_q   <= done_d;
      fail_q   <= fail_d;
    end
  end

  assign scl_pull = scl_q;
  assign sda_pull = sda_q;
  assign done     = done_q;
  assign fail     = fail_q;

endmodule

// File: rtl/twi_unstick.sv
module twi_unstick #(
  parameter int LOW_CYC     = 260,
  parameter int HIGH_CYC    = 140,
  parameter int SETUP_CYC   = 130,
  parameter int HOLD_CYC    = 130,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic done,
  output logic fail
);

  localparam int MAX_A = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_B = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam int PW    = $clog2(MAX_PULSES + 1);

  logic          sda_s;
  logic          t_load, t_expired;
  logic [TW-1:0] t_val;

  twiu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sda_in),
    .q_sync  (sda_s)
  );

  twiu_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  twiu_fsm #(
    .LOW_CYC    (LOW_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .MAX_PULSES (MAX_PULSES),
    .TW         (TW),
    .PW         (PW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (recover_req),
    .sda_s     (sda_s),
    .t_expired (t_expired),
    .t_load    (t_load),
    .t_val     (t_val),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .done      (done),
    .fail      (fail)
  );

endmodule

// File: rtl/twiu_chk.sv
module twiu_chk #(
  parameter int LOW_CYC    = 260,
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic scl_pull,
  input logic sda_pull,
  input logic done,
  input logic fail
);

  logic [31:0] low_run_q;
  logic [31:0] pulse_cnt_q;
  logic        scl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q   <= '0;
      pulse_cnt_q <= '0;
      scl_prev_q  <= 1'b0;
    end else begin
      scl_prev_q <= scl_pull;
      low_run_q  <= scl_pull ? low_run_q + 1 : '0;
      if (done || fail)              pulse_cnt_q <= '0;
      else if (scl_pull && !scl_prev_q) pulse_cnt_q <= pulse_cnt_q + 1;
    end
  end

  assert_start_under_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (!scl_pull && !$past(scl_pull)));

  assert_stop_under_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);

  assert_done_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_pull && !sda_pull && !fail));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!scl_pull && !sda_pull));

  assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> (low_run_q == 32'(LOW_CYC)));

  assert_pulse_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt_q <= 32'(MAX_PULSES));

endmodule

bind twi_unstick twiu_chk #(
  .LOW_CYC    (LOW_CYC),
  .MAX_PULSES (MAX_PULSES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .done     (done),
  .fail     (fail)
);

// File: tb/sim_twi_unstick.sv
module sim_twi_unstick;

  localparam int LOW   = 6;
  localparam int HIGH  = 4;
  localparam int SU    = 3;
  localparam int HD    = 5;
  localparam int MAXP  = 9;

  logic clk, rst_n, recover_req, sda_in;
  logic scl_pull, sda_pull, done, fail;

  int checks, failures, cycles;
  int pulses, lrun, hrun, hdrun, lerr, herr, serr, ferr, starts, dones, fails_seen;
  int k_release;
  logic slave_hold, prev_scl, prev_sda, mon_en;

  twi_unstick #(
    .LOW_CYC(LOW), .HIGH_CYC(HIGH), .SETUP_CYC(SU), .HOLD_CYC(HD),
    .MAX_PULSES(MAXP), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .done(done), .fail(fail)
  );

  assign sda_in = !(slave_hold || sda_pull);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_pulses(int k);
    return (k + 1 > MAXP) ? MAXP : k + 1;
  endfunction

  function automatic bit exp_fail(int k);
    return (k >= MAXP);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (mon_en) begin
      if (scl_pull && !prev_scl) begin
        if (pulses >= 1 && hrun != HIGH) herr++;
        pulses++;
        if (pulses == k_release + 1) slave_hold = 1'b0;
      end
      if (!scl_pull && prev_scl && lrun != LOW) lerr++;
      if (sda_pull && !prev_sda) begin
        starts++;
        if (scl_pull || hrun != HIGH + SU) serr++;
      end
      if (!sda_pull && prev_sda && (scl_pull || hdrun != HD)) serr++;
      if (done) begin
        dones++;
        if (scl_pull || sda_pull || !prev_sda) serr++;
      end
      if (fail) begin
        fails_seen++;
        if (scl_pull || sda_pull) ferr++;
      end
      lrun  = scl_pull ? lrun + 1 : 0;
      hrun  = !scl_pull ? hrun + 1 : 0;
      hdrun = sda_pull ? hdrun + 1 : 0;
    end
    prev_scl = scl_pull;
    prev_sda = sda_pull;
  end

  task automatic run_trial(int k, int inj);
    int waited;
    bit quiet;
    k_release  = k;
    slave_hold = (k > 0);
    pulses = 0; lrun = 0; hrun = 0; hdrun = 0;
    lerr = 0; herr = 0; serr = 0; ferr = 0;
    starts = 0; dones = 0; fails_seen = 0;
    mon_en = 1'b1;
    recover_req = 1'b1;
    @(negedge clk);
    recover_req = 1'b0;
    chk(scl_pull == 1'b1, "R2", int'(scl_pull), 1);
    waited = 0;
    while (!(done || fail) && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (inj > 0 && waited == inj) recover_req = 1'b1;
      else recover_req = 1'b0;
    end
    recover_req = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (scl_pull || sda_pull || done || fail) quiet = 1'b0;
    end
    chk(pulses == exp_pulses(k), "R4/R9 pulse count", pulses, exp_pulses(k));
    chk(fails_seen == int'(exp_fail(k)), "R7 fail pulse", fails_seen, int'(exp_fail(k)));
    chk(dones == int'(!exp_fail(k)), "R6 done pulse", dones, int'(!exp_fail(k)));
    chk(starts == int'(!exp_fail(k)), "R4/R5 start count", starts, int'(!exp_fail(k)));
    chk(lerr == 0 && herr == 0, "R3 phase width", lerr + herr, 0);
    chk(serr == 0 && ferr == 0, "R5/R6/R7 condition timing", serr + ferr, 0);
    chk(quiet, inj > 0 ? "R8 busy request ignored" : "R1 idle after sequence", int'(quiet), 1);
    mon_en = 1'b0;
    slave_hold = 1'b0;
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0;
    mon_en = 1'b0; slave_hold = 1'b0; recover_req = 1'b0;
    prev_scl = 1'b0; prev_sda = 1'b0; k_release = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!scl_pull && !sda_pull && !done && !fail, "R1 reset state",
        int'({scl_pull, sda_pull, done, fail}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull, "R1 idle after reset", int'({scl_pull, sda_pull}), 0);

    run_trial(0, 0);
    run_trial(MAXP - 1, 0);
    run_trial(MAXP, 0);
    run_trial(MAXP + 3, 0);
    run_trial(3, 2);
    run_trial(MAXP, 4);
    for (int t = 0; t < 14; t++) begin
      int k, inj;
      k   = int'($urandom_range(0, MAXP + 2));
      inj = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 5)) : 0;
      run_trial(k, inj);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule